// File: doc/BRIEF.md
# DMA Channel Control and Transfer Counter

This block is the control half of one DMA channel. A CPU-side register port reaches two 16-bit registers: a control word that holds the channel's mode bits and its run flag, and a transfer counter. While the channel runs, it turns an external request pin and an internal timer pulse into a request to the bus. The sync mode and two enable bits decide how that happens. A one-cycle done strobe marks each completed bus transfer.

Each done strobe counts the counter down. Depending on the sync mode and a stop-on-zero bit, the channel clears its own run flag when the count reaches zero. The run flag can only be changed by a control write that also sets a change-enable bit. This lets software change the size, priority or request setup of a running channel without stopping it. The request pin can also serve as a plain interrupt input. Address generation, the bus cycles themselves and arbitration between channels belong to other blocks.

Top module: `dma_chan_ctl`

## Requirements
- R1: Control register fields: bit 0 run, bit 1 change-enable, bit 2 word size, bit 3 high priority, bit 4 timer-request enable, bit 5 pin-as-interrupt, bit 6 stop-on-zero, bits 8:7 sync mode (00 unsynchronized, 01 source-synchronized, 10 destination-synchronized, 11 reserved). A read with `reg_sel_i`=0 returns these fields, and bits 15:9 read 0.
- R2: The run bit takes the written value only when the same control write has bit 1 set. Otherwise it keeps its value while the other fields update.
- R3: The change-enable bit is not stored, so control reads always return 0 in bit 1.
- R4: While reset is asserted, every control field is 0, and `active_o`, `bus_req_o` and `irq_o` are 0.
- R5: A write with `reg_sel_i`=1 loads the counter. Each `xfer_done_i` cycle while running decrements it by one, wrapping from 0x0000 to 0xFFFF, and a read with `reg_sel_i`=1 returns it.
- R6: When a decrement brings the count to 0 and either the mode is 00 or stop-on-zero is set, the run bit clears on that edge. In other cases the channel keeps running.
- R7: `bus_req_o` is 0 while the channel is stopped. While running it is 1 in mode 00 and 0 in mode 11. In modes 01 and 10 it is 1 only while an enabled request source is active.
- R8: The timer input counts as a request source only when timer-request enable is 1.
- R9: With pin-as-interrupt set, `irq_o` follows the request pin and the pin is no longer a request source. With it clear, `irq_o` is 0.
- R10: `word_o` and `prio_hi_o` reflect the stored size and priority bits.
- R11: A counter write in the same cycle as a done strobe wins over the decrement. A change-enabled control write wins over a stop on zero in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 control, 1 counter |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data of the selected register |
| drq_pin_i | input | 1 | External request / interrupt pin |
| tmr_req_i | input | 1 | Internal timer request |
| xfer_done_i | input | 1 | One completed transfer this cycle |
| active_o | output | 1 | Run bit |
| bus_req_o | output | 1 | Transfer request to the bus |
| word_o | output | 1 | 1 word, 0 byte transfers |
| prio_hi_o | output | 1 | Channel is high priority |
| irq_o | output | 1 | Interrupt from the request pin |

## Verification
The assertions check on every cycle that the run flag rises only through a change-enabled write and falls only through such a write or a stop on zero. They also check that bit 1 reads 0, that each done strobe decrements the count, that a terminal decrement stops the channel, and that no request leaves a stopped or reserved-mode channel. The bench scenarios and the per-cycle reference model show the rest: the read-back layout of every field, the masking by the timer and pin-interrupt enables, the wrap from zero in synchronized modes, and which write wins when a write and a done strobe arrive together.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned B_RUN     = 0;
  localparam int unsigned B_CHG     = 1;
  localparam int unsigned B_WORD    = 2;
  localparam int unsigned B_PRIO    = 3;
  localparam int unsigned B_TMR     = 4;
  localparam int unsigned B_PIN_IRQ = 5;
  localparam int unsigned B_TC_STOP = 6;
  localparam int unsigned B_MODE_LO = 7;
  localparam int unsigned B_MODE_HI = B_MODE_LO + 1;

  typedef enum logic [1:0] {
    SYNC_NONE = 2'b00,
    SYNC_SRC  = 2'b01,
    SYNC_DST  = 2'b10,
    SYNC_RSVD = 2'b11
  } sync_mode_e;

  typedef struct packed {
    sync_mode_e mode;
    logic       tc_stop;
    logic       pin_irq;
    logic       tmr_en;
    logic       prio_hi;
    logic       word;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/dma_ctl_reg.sv
module dma_ctl_reg
  import dma_chan_pkg::*;
#(
  parameter int unsigned DW = REG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          term_i,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] image_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_i) begin
      ctrl_q.mode    <= sync_mode_e'(wdata_i[B_MODE_HI:B_MODE_LO]);
      ctrl_q.tc_stop <= wdata_i[B_TC_STOP];
      ctrl_q.pin_irq <= wdata_i[B_PIN_IRQ];
      ctrl_q.tmr_en  <= wdata_i[B_TMR];
      ctrl_q.prio_hi <= wdata_i[B_PRIO];
      ctrl_q.word    <= wdata_i[B_WORD];
      // run moves only with change-enable; otherwise a stop on zero still applies
      ctrl_q.run     <= wdata_i[B_CHG] ? wdata_i[B_RUN] : (ctrl_q.run & ~term_i);
    end else if (term_i) begin
      ctrl_q.run <= 1'b0;
    end
  end

  always_comb begin
    image_o                       = '0;
    image_o[B_RUN]                = ctrl_q.run;
    image_o[B_WORD]               = ctrl_q.word;
    image_o[B_PRIO]               = ctrl_q.prio_hi;
    image_o[B_TMR]                = ctrl_q.tmr_en;
    image_o[B_PIN_IRQ]            = ctrl_q.pin_irq;
    image_o[B_TC_STOP]            = ctrl_q.tc_stop;
    image_o[B_MODE_HI:B_MODE_LO]  = ctrl_q.mode;
  end

  assign ctrl_o = ctrl_q;

  logic unused_hi;
  assign unused_hi = ^wdata_i[DW-1:B_MODE_HI+1];
endmodule

// File: rtl/dma_xfer_cnt.sv
module dma_xfer_cnt #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          ld_i,
  input  logic [CW-1:0] ld_val_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  // no reset: contents undefined until software loads it
  always_ff @(posedge clk_i) begin
    if (ld_i)       cnt_q <= ld_val_i;
    else if (dec_i) cnt_q <= cnt_q - CW'(1);
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/dma_req_qual.sv
module dma_req_qual
  import dma_chan_pkg::*;
(
  input  ctrl_t ctrl_i,
  input  logic  pin_i,
  input  logic  tmr_i,
  output logic  req_o,
  output logic  irq_o
);
  logic pin_req, tmr_req, src_ok;

  assign pin_req = pin_i & ~ctrl_i.pin_irq;
  assign tmr_req = tmr_i & ctrl_i.tmr_en;

  always_comb begin
    unique case (ctrl_i.mode)
      SYNC_NONE:          src_ok = 1'b1;
      SYNC_SRC, SYNC_DST: src_ok = pin_req | tmr_req;
      default:            src_ok = 1'b0;
    endcase
  end

  assign req_o = ctrl_i.run & src_ok;
  assign irq_o = ctrl_i.pin_irq & pin_i;
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
#(
  parameter int unsigned DW = REG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic          reg_sel_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          drq_pin_i,
  input  logic          tmr_req_i,
  input  logic          xfer_done_i,
  output logic          active_o,
  output logic          bus_req_o,
  output logic          word_o,
  output logic          prio_hi_o,
  output logic          irq_o
);
  ctrl_t         ctrl;
  logic [DW-1:0] ctrl_image, count_val;
  logic          wr_ctrl, wr_cnt, dec, cnt_last, stop_en, term;

  assign wr_ctrl = reg_wr_i & ~reg_sel_i;
  assign wr_cnt  = reg_wr_i &  reg_sel_i;
  assign dec     = xfer_done_i & ctrl.run;
  assign stop_en = (ctrl.mode == SYNC_NONE) | ctrl.tc_stop;
  assign term    = dec & cnt_last & stop_en & ~wr_cnt;

  dma_ctl_reg #(.DW(DW)) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_ctrl),
    .wdata_i (reg_wdata_i),
    .term_i  (term),
    .ctrl_o  (ctrl),
    .image_o (ctrl_image)
  );

  dma_xfer_cnt #(.CW(DW)) u_cnt (
    .clk_i    (clk_i),
    .ld_i     (wr_cnt),
    .ld_val_i (reg_wdata_i),
    .dec_i    (dec),
    .cnt_o    (count_val),
    .last_o   (cnt_last)
  );

  dma_req_qual u_req (
    .ctrl_i (ctrl),
    .pin_i  (drq_pin_i),
    .tmr_i  (tmr_req_i),
    .req_o  (bus_req_o),
    .irq_o  (irq_o)
  );

  assign reg_rdata_o = reg_sel_i ? count_val : ctrl_image;
  assign active_o    = ctrl.run;
  assign word_o      = ctrl.word;
  assign prio_hi_o   = ctrl.prio_hi;
endmodule

// File: rtl/dma_chan_ctl_chk.sv
module dma_chan_ctl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_wr_i,
  input logic        reg_sel_i,
  input logic [15:0] reg_wdata_i,
  input logic [15:0] reg_rdata_o,
  input logic        drq_pin_i,
  input logic        xfer_done_i,
  input logic        active_o,
  input logic        bus_req_o,
  input logic        irq_o,
  input logic [15:0] count_val,
  input logic [1:0]  mode_val,
  input logic        tc_stop_val
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_idle_r4: assert (!active_o && !bus_req_o && !irq_o);
    end
  end

  p_run_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(reg_wr_i && !reg_sel_i && reg_wdata_i[1] && reg_wdata_i[0]));

  p_run_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> $past((reg_wr_i && !reg_sel_i && reg_wdata_i[1]) ||
                              (xfer_done_i && count_val == 16'd1 &&
                               (mode_val == 2'b00 || tc_stop_val))));

  p_chg_reads_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_sel_i |-> !reg_rdata_o[1]);

  p_count_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_done_i && active_o && !(reg_wr_i && reg_sel_i)) |=>
      count_val == $past(count_val) - 16'd1);

  p_stop_at_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_done_i && active_o && count_val == 16'd1 && (mode_val == 2'b00 || tc_stop_val) &&
     !reg_wr_i) |=> !active_o);

  p_idle_no_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> !bus_req_o);

  p_rsvd_no_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_val == 2'b11 |-> !bus_req_o);

  p_irq_from_pin_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> drq_pin_i);
endmodule

bind dma_chan_ctl dma_chan_ctl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .drq_pin_i   (drq_pin_i),
  .xfer_done_i (xfer_done_i),
  .active_o    (active_o),
  .bus_req_o   (bus_req_o),
  .irq_o       (irq_o),
  .count_val   (count_val),
  .mode_val    (ctrl.mode),
  .tc_stop_val (ctrl.tc_stop)
);

// File: tb/dma_chan_ctl_tb_top.sv
module dma_chan_ctl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, sel = 1'b0, pin = 1'b0, tmr = 1'b0, done = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        active, breq, word, prio, irq;

  int total = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_ctl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .drq_pin_i(pin), .tmr_req_i(tmr), .xfer_done_i(done),
    .active_o(active), .bus_req_o(breq), .word_o(word), .prio_hi_o(prio), .irq_o(irq)
  );

  // behavioural reference model
  bit m_run, m_word, m_prio, m_tmr, m_pirq, m_tcs, m_known;
  int m_mode, m_cnt;

  function automatic bit exp_req();
    bit src;
    if (!m_run) return 0;
    if (m_mode == 0) return 1;
    if (m_mode == 3) return 0;
    src = (pin && !m_pirq) || (tmr && m_tmr);
    return src;
  endfunction

  function automatic int exp_ctrl();
    return m_run + 4*m_word + 8*m_prio + 16*m_tmr + 32*m_pirq + 64*m_tcs + 128*m_mode;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_word = 0; m_prio = 0; m_tmr = 0; m_pirq = 0; m_tcs = 0; m_mode = 0;
    end else begin
      bit nrun;
      int ncnt;
      nrun = m_run; ncnt = m_cnt;
      if (done && m_run) begin
        ncnt = (m_cnt + 65535) % 65536;
        if (m_known && ncnt == 0 && (m_mode == 0 || m_tcs)) nrun = 0;
      end
      if (wr && sel) begin ncnt = int'(wdata); m_known = 1; nrun = m_run; end
      if (wr && !sel) begin
        m_word = wdata[2]; m_prio = wdata[3]; m_tmr = wdata[4];
        m_pirq = wdata[5]; m_tcs = wdata[6]; m_mode = int'(wdata[8:7]);
        if (wdata[1]) nrun = wdata[0];
      end
      m_run = nrun; m_cnt = ncnt;
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(16'(active), 16'(m_run), "R6 active_o vs model");
      chk(16'(breq), 16'(exp_req()), "R7 bus_req_o vs model");
      chk(16'(word), 16'(m_word), "R10 word_o vs model");
      chk(16'(prio), 16'(m_prio), "R10 prio_hi_o vs model");
      chk(16'(irq), 16'(m_pirq && pin), "R9 irq_o vs model");
      if (!sel) chk(rdata, 16'(exp_ctrl()), "R1 control read vs model");
      else if (m_known) chk(rdata, 16'(m_cnt), "R5 counter read vs model");
    end
  end

  task automatic nxt();
    @(negedge clk); #1;
  endtask

  task automatic wreg(input logic s, input logic [15:0] d);
    wr = 1; sel = s; wdata = d; nxt(); wr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) nxt();
    chk(16'(active), 16'd0, "R4 active in reset");
    chk(16'(breq), 16'd0, "R4 bus_req in reset");
    chk(rdata, 16'h0000, "R4 control zero in reset");
    rst_n = 1; nxt();

    // unsynchronized run to zero
    wreg(1, 16'd3);
    wreg(0, 16'h000F);
    sel = 0; #1;
    chk(rdata, 16'h000D, "R1 R3 control readback");
    chk(16'(breq), 16'd1, "R7 unsync requests");
    chk(16'({word, prio}), 16'b11, "R10 size/priority");
    done = 1; repeat (3) nxt(); done = 0;
    chk(16'(active), 16'd0, "R6 unsync stop at zero");
    sel = 1; #1; chk(rdata, 16'h0000, "R5 count reached zero");

    // run without change-enable
    wreg(0, 16'h0001);
    chk(16'(active), 16'd0, "R2 run ignored without change-enable");
    sel = 0; #1; chk(rdata, 16'h0000, "R2 control readback");

    // source-synchronized, timer enabled, no stop on zero
    wreg(1, 16'd1);
    wreg(0, 16'h0093);
    chk(16'(breq), 16'd0, "R7 sync idle no request");
    tmr = 1; #1; chk(16'(breq), 16'd1, "R8 timer request enabled");
    done = 1; nxt();
    chk(16'(active), 16'd1, "R6 sync keeps running at zero");
    nxt(); done = 0; tmr = 0;
    sel = 1; #1; chk(rdata, 16'hFFFF, "R5 wrap to FFFF");

    // change fields while running, timer disabled
    wreg(0, 16'h0080);
    chk(16'(active), 16'd1, "R2 run held on write without change-enable");
    tmr = 1; #1; chk(16'(breq), 16'd0, "R8 timer masked");
    tmr = 0; pin = 1; #1; chk(16'(breq), 16'd1, "R7 pin request");
    pin = 0; wreg(0, 16'h00A0);
    pin = 1; #1;
    chk(16'(irq), 16'd1, "R9 pin as interrupt");
    chk(16'(breq), 16'd0, "R9 pin no longer requests");
    pin = 0; #1; chk(16'(irq), 16'd0, "R9 irq follows pin");

    // reserved mode
    wreg(0, 16'h0180);
    pin = 1; tmr = 1; #1; chk(16'(breq), 16'd0, "R7 reserved mode never requests");
    pin = 0; tmr = 0;

    // destination-synchronized with stop on zero
    wreg(1, 16'd2);
    wreg(0, 16'h0143);
    pin = 1; #1; chk(16'(breq), 16'd1, "R7 dest sync pin request");
    done = 1; repeat (2) nxt(); done = 0; pin = 0;
    chk(16'(active), 16'd0, "R6 stop-on-zero in sync mode");

    // collisions
    wreg(1, 16'd5);
    wreg(0, 16'h0083);
    wr = 1; sel = 1; wdata = 16'd9; done = 1; nxt(); wr = 0; done = 0;
    #1; chk(rdata, 16'd9, "R11 counter write beats decrement");
    wreg(0, 16'h0082);
    chk(16'(active), 16'd0, "R2 stop via change-enable");
    wreg(1, 16'd1);
    wreg(0, 16'h0003);
    wr = 1; sel = 0; wdata = 16'h0003; done = 1; nxt(); wr = 0; done = 0;
    chk(16'(active), 16'd1, "R11 change-enabled write beats stop");

    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      wr = ($urandom_range(0, 7) == 0);
      sel = 1'($urandom_range(0, 1));
      wdata = sel ? 16'($urandom_range(0, 3)) : (16'($urandom) & 16'h01FF);
      pin = 1'($urandom_range(0, 1));
      tmr = 1'($urandom_range(0, 1));
      done = 1'($urandom_range(0, 1));
      nxt();
    end
    wr = 0; done = 0;
    nxt();
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule